// File: doc/BRIEF.md
# Chainable Associative Memory Slice

This block is one slice of a content-addressable memory that is meant to be stacked vertically. Each slice holds a parameterised number of 32-bit words with a valid bit apiece. A compare command presents a key; every valid word equal to the key is flagged, and the lowest-index hit becomes the slice's priority match. A per-slice page register supplies the upper bits of a system-wide address. Because of this, the single slice that wins can put the complete address on the bus without any external encoder.

Slices are linked by two active-low daisy chains. The match chain tells every slice whether any slice upstream already matched. The full chain tells it whether every slice upstream is full. The first slice ties its upstream match input high (no match) and its upstream full input low (all full). The last slice's chain outputs are the system match and system full flags. With these chains, only one slice answers a read, takes a write aimed at the priority match, or takes a write aimed at the next free location. Reads that need a match are refused everywhere when no slice matched, so no two slices drive the shared bus together. A select register lets software target one slice, or all slices when it holds all ones.

Each cycle with `en_i` high is one bus operation. `we_i` picks write or read, and `op_i` picks the command. Read data is combinational from state, and `oe_o` marks the one slice that drives it.

Top module: `cam_slice`

## Requirements
- R1: After reset all valid bits and compare hits are clear, the page register is 0 and the select register is all ones. `ma_n_o`, `mm_n_o` and `mf_n_o` are high. `ff_n_o` is high unless the slice sits below a chain in which every slice is full.
- R2: A compare write (`we_i`=1, `op_i`=0) in a selected slice captures the hits of the key `wdata_i` against all valid words. From the next clock on, `ma_n_o` is low if at least one word hit and `mm_n_o` is low if two or more hit. Unselected slices keep their previous hits.
- R3: A status read (`we_i`=0, `op_i`=0) returns the lowest hit index in bits [AW-1:0] and the page register in bits [AW+PW-1:AW]. Bit 31 is the match flag, bit 30 the multiple-match flag and bit 29 the full flag. All other bits are 0.
- R4: `mf_n_o` is low exactly when `mi_n_i` is low or the slice has a hit.
- R5: `ff_n_o` is low exactly when `fi_n_i` is low and every word of the slice is valid.
- R6: A slice owns the match when it has a hit and `mi_n_i` is high. Only that slice drives `oe_o` high for the status (0), matched-word (1), page (3), select (4) and indexed-word (5) reads. Read op 1 returns the word at the lowest hit, and op 5 returns the word at `addr_i`. When no slice owns the match, no slice drives these reads. A slice that does not drive returns 0 on `rdata_o`.
- R7: A next-free read (`op_i`=2) is driven only by the slice whose `fi_n_i` is low and which has a free word. It returns the lowest free index in bits [AW-1:0], the page in bits [AW+PW-1:AW], and zeros elsewhere.
- R8: An indexed write (`op_i`=1) stores `wdata_i` at `addr_i` and sets its valid bit, and an indexed clear (`op_i`=4) clears that valid bit. Both act only in slices whose select register equals their page register or is all ones.
- R9: A matched write (`op_i`=2) overwrites the word at the lowest hit and keeps it valid, only in the slice that owns the match.
- R10: A next-free write (`op_i`=3) stores `wdata_i` at the lowest free index and sets its valid bit, only in the slice that owns the next-free location. When the whole chain is full, nothing changes.
- R11: A page write (`op_i`=5) loads `wdata_i[PW-1:0]` into selected slices. A select write (`op_i`=6) loads `wdata_i[PW-1:0]` into every enabled slice.
- R12: With `en_i` low, no state changes, `oe_o` stays low and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Bus operation enable for this slice |
| we_i | input | 1 | 1 = write/command, 0 = read |
| op_i | input | 3 | Operation code |
| addr_i | input | AW | Word index for indexed operations |
| wdata_i | input | DW | Write data or compare key |
| rdata_o | output | DW | Read data, 0 when not driving |
| oe_o | output | 1 | This slice drives the read bus |
| mi_n_i | input | 1 | Upstream match chain, active low |
| fi_n_i | input | 1 | Upstream full chain, active low |
| ma_n_o | output | 1 | Local match, active low |
| mm_n_o | output | 1 | Local multiple match, active low |
| mf_n_o | output | 1 | Downstream match chain, active low |
| ff_n_o | output | 1 | Downstream full chain, active low |

## Verification
Local match detection and chain ownership meet in the same cycle. A slice can have a hit while the upstream match input is also asserted, and then it must neither answer reads nor take a matched write. The bench provokes this by loading the same word into several slices of a three-slice chain and comparing against it. It then checks that the bus driver mask names only the upstream-most hitting slice, and that a matched write lands only there, using a follow-up compare and reads. The full chain and the next-free owner are stressed the same way. The chain is filled to the last word and then given one more next-free write.

// File: rtl/cam_slice_pkg.sv
package cam_slice_pkg;

    // write commands (we_i = 1)
    localparam logic [2:0] WOP_COMPARE = 3'd0;
    localparam logic [2:0] WOP_AT_ADDR = 3'd1;
    localparam logic [2:0] WOP_AT_HIT  = 3'd2;
    localparam logic [2:0] WOP_AT_FREE = 3'd3;
    localparam logic [2:0] WOP_CLEAR   = 3'd4;
    localparam logic [2:0] WOP_PAGE    = 3'd5;
    localparam logic [2:0] WOP_SELECT  = 3'd6;

    // read selectors (we_i = 0)
    localparam logic [2:0] ROP_STATUS  = 3'd0;
    localparam logic [2:0] ROP_HITWORD = 3'd1;
    localparam logic [2:0] ROP_FREE    = 3'd2;
    localparam logic [2:0] ROP_PAGE    = 3'd3;
    localparam logic [2:0] ROP_SELECT  = 3'd4;
    localparam logic [2:0] ROP_WORD    = 3'd5;

    // flag positions counted down from the top of the status word
    localparam int FLAG_MATCH_OFS = 1;
    localparam int FLAG_MULTI_OFS = 2;
    localparam int FLAG_FULL_OFS  = 3;

endpackage

// File: rtl/cam_first_set.sv
// Lowest-index set bit finder with a "more than one" indication.
module cam_first_set #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o,
    output logic          multi_o
);
    always_comb begin
        idx_o   = '0;
        any_o   = 1'b0;
        multi_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                if (any_o) begin
                    multi_o = 1'b1;
                end else begin
                    idx_o = IW'(i);
                    any_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cam_hit_array.sv
// Parallel equality compare of a key against every valid word.
module cam_hit_array #(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input  logic [N-1:0][DW-1:0] words_i,
    input  logic [N-1:0]         valid_i,
    input  logic [DW-1:0]        key_i,
    output logic [N-1:0]         hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        assign hit_o[g] = valid_i[g] && (words_i[g] == key_i);
    end
endmodule

// File: rtl/cam_slice.sv
module cam_slice
    import cam_slice_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int DW      = 32,
    parameter int PW      = 16,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [2:0]    op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          oe_o,
    input  logic          mi_n_i,
    input  logic          fi_n_i,
    output logic          ma_n_o,
    output logic          mm_n_o,
    output logic          mf_n_o,
    output logic          ff_n_o
);
    localparam int MATCH_BIT = DW - FLAG_MATCH_OFS;
    localparam int MULTI_BIT = DW - FLAG_MULTI_OFS;
    localparam int FULL_BIT  = DW - FLAG_FULL_OFS;

    typedef struct packed {
        logic [ENTRIES-1:0][DW-1:0] mem;
        logic [ENTRIES-1:0]         valid;
        logic [ENTRIES-1:0]         hits;
        logic [PW-1:0]              page;
        logic [PW-1:0]              dsel;
    } slice_st_t;

    localparam slice_st_t ST_RESET = '{mem: '0, valid: '0, hits: '0, page: '0, dsel: '1};

    slice_st_t st_d, st_q;
    logic      seen_q;

    logic [ENTRIES-1:0] key_hit;
    logic [AW-1:0]      hit_idx, free_idx;
    logic               loc_match, loc_multi, has_free, loc_full;
    logic               selected, own_hit, own_free, addr_ok;
    logic               wr_go, rd_go, drive;
    logic [DW-1:0]      rd_word;

    cam_hit_array #(.N(ENTRIES), .DW(DW)) u_hits (
        .words_i (st_q.mem),
        .valid_i (st_q.valid),
        .key_i   (wdata_i),
        .hit_o   (key_hit)
    );

    cam_first_set #(.N(ENTRIES), .IW(AW)) u_hit_enc (
        .vec_i   (st_q.hits),
        .idx_o   (hit_idx),
        .any_o   (loc_match),
        .multi_o (loc_multi)
    );

    cam_first_set #(.N(ENTRIES), .IW(AW)) u_free_enc (
        .vec_i   (~st_q.valid),
        .idx_o   (free_idx),
        .any_o   (has_free),
        .multi_o ()
    );

    assign loc_full = ~has_free;
    assign selected = (st_q.dsel == st_q.page) || (&st_q.dsel);
    assign own_hit  = loc_match & mi_n_i;
    assign own_free = has_free & ~fi_n_i;
    assign addr_ok  = (int'(addr_i) < ENTRIES);
    assign wr_go    = en_i & we_i;
    assign rd_go    = en_i & ~we_i;

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            case (op_i)
                WOP_COMPARE: if (selected) st_d.hits = key_hit;
                WOP_AT_ADDR: if (selected && addr_ok) begin
                    st_d.mem[addr_i]   = wdata_i;
                    st_d.valid[addr_i] = 1'b1;
                end
                WOP_AT_HIT: if (own_hit) begin
                    st_d.mem[hit_idx]   = wdata_i;
                    st_d.valid[hit_idx] = 1'b1;
                end
                WOP_AT_FREE: if (own_free) begin
                    st_d.mem[free_idx]   = wdata_i;
                    st_d.valid[free_idx] = 1'b1;
                end
                WOP_CLEAR:   if (selected && addr_ok) st_d.valid[addr_i] = 1'b0;
                WOP_PAGE:    if (selected) st_d.page = wdata_i[PW-1:0];
                WOP_SELECT:  st_d.dsel = wdata_i[PW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RESET;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            seen_q <= 1'b1;
        end
    end

    // read path: only the owning slice drives
    always_comb begin
        rd_word = '0;
        drive   = 1'b0;
        case (op_i)
            ROP_STATUS: begin
                drive                 = own_hit;
                rd_word[AW-1:0]       = hit_idx;
                rd_word[AW +: PW]     = st_q.page;
                rd_word[MATCH_BIT]    = loc_match;
                rd_word[MULTI_BIT]    = loc_multi;
                rd_word[FULL_BIT]     = loc_full;
            end
            ROP_HITWORD: begin
                drive   = own_hit;
                rd_word = st_q.mem[hit_idx];
            end
            ROP_FREE: begin
                drive             = own_free;
                rd_word[AW-1:0]   = free_idx;
                rd_word[AW +: PW] = st_q.page;
            end
            ROP_PAGE: begin
                drive           = own_hit;
                rd_word[PW-1:0] = st_q.page;
            end
            ROP_SELECT: begin
                drive           = own_hit;
                rd_word[PW-1:0] = st_q.dsel;
            end
            ROP_WORD: begin
                drive   = own_hit && addr_ok;
                rd_word = addr_ok ? st_q.mem[addr_i] : '0;
            end
            default: ;
        endcase
    end

    assign oe_o    = rd_go & drive;
    assign rdata_o = oe_o ? rd_word : '0;

    assign ma_n_o = ~loc_match;
    assign mm_n_o = ~loc_multi;
    assign mf_n_o = mi_n_i & ~loc_match;
    assign ff_n_o = fi_n_i | has_free;

    // compare result appears one clock after a selected compare (R2)
    assert_cmp_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(wr_go && op_i == WOP_COMPARE && selected)
        |-> (ma_n_o == ~$past(|key_hit)));

    assert_multi_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mm_n_o |-> !ma_n_o);

    // upstream match always propagates down the chain (R4)
    assert_match_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mi_n_i |-> !mf_n_o);

    // an upstream slice with room blocks the full chain (R5)
    assert_full_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fi_n_i |-> ff_n_o);

    // match-gated reads are only driven by the owning slice (R6)
    assert_read_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && op_i != ROP_FREE) |-> (!ma_n_o && mi_n_i));

    // a next-free write leaves its target valid (R10)
    assert_free_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(wr_go && op_i == WOP_AT_FREE && own_free)
        |-> st_q.valid[$past(free_idx)]);

    // a disabled cycle changes nothing (R12)
    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(!en_i)
        |-> (st_q.valid == $past(st_q.valid) && st_q.page == $past(st_q.page)
             && st_q.dsel == $past(st_q.dsel)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!oe_o && rdata_o == '0));

endmodule

// File: tb/cam_slice_bench.sv
`timescale 1ns/1ps
module cam_slice_bench;
    import cam_slice_pkg::*;

    localparam int N  = 8;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int PW = 16;
    localparam int S  = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [S-1:0]  en;
    logic          we;
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata [S];
    logic [S-1:0]  oe, ma_n, mm_n, mf_n, ff_n, mi_n, fi_n;

    for (genvar s = 0; s < S; s++) begin : g_slice
        if (s == 0) begin : g_head
            assign mi_n[s] = 1'b1;
            assign fi_n[s] = 1'b0;
        end else begin : g_tail
            assign mi_n[s] = mf_n[s-1];
            assign fi_n[s] = ff_n[s-1];
        end
        cam_slice #(.ENTRIES(N), .DW(DW), .PW(PW)) u_cam_slice (
            .clk(clk), .rst_n(rst_n), .en_i(en[s]), .we_i(we), .op_i(op),
            .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata[s]), .oe_o(oe[s]),
            .mi_n_i(mi_n[s]), .fi_n_i(fi_n[s]), .ma_n_o(ma_n[s]), .mm_n_o(mm_n[s]),
            .mf_n_o(mf_n[s]), .ff_n_o(ff_n[s])
        );
    end

    // reference model
    logic [DW-1:0] m_mem  [S][N];
    bit            m_val  [S][N];
    bit            m_hit  [S][N];
    logic [PW-1:0] m_page [S];
    logic [PW-1:0] m_dsel [S];

    int n_cmp = 0;
    int n_bad = 0;
    logic [DW-1:0] pool [4] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0007};

    function automatic int first_hit(int s);
        for (int i = 0; i < N; i++) if (m_hit[s][i]) return i;
        return -1;
    endfunction
    function automatic int hit_count(int s);
        int c = 0;
        for (int i = 0; i < N; i++) if (m_hit[s][i]) c++;
        return c;
    endfunction
    function automatic int first_free(int s);
        for (int i = 0; i < N; i++) if (!m_val[s][i]) return i;
        return -1;
    endfunction
    function automatic int hit_owner();
        for (int s = 0; s < S; s++) if (first_hit(s) >= 0) return s;
        return -1;
    endfunction
    function automatic int free_owner();
        for (int s = 0; s < S; s++) if (first_free(s) >= 0) return s;
        return -1;
    endfunction
    function automatic bit is_sel(int s);
        return (m_dsel[s] == m_page[s]) || (m_dsel[s] == '1);
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < S; s++) begin
            for (int i = 0; i < N; i++) begin
                m_mem[s][i] = '0; m_val[s][i] = 0; m_hit[s][i] = 0;
            end
            m_page[s] = '0; m_dsel[s] = '1;
        end
    endtask

    // one write cycle; model updated from pre-cycle state
    task automatic do_wr(logic [S-1:0] mask, logic [2:0] o, int a, logic [DW-1:0] d);
        int ho, fo;
        @(negedge clk);
        en = mask; we = 1'b1; op = o; addr = AW'(a); wdata = d;
        ho = hit_owner(); fo = free_owner();
        for (int s = 0; s < S; s++) begin
            if (mask[s]) begin
                case (o)
                    WOP_COMPARE: if (is_sel(s))
                        for (int i = 0; i < N; i++) m_hit[s][i] = m_val[s][i] && (m_mem[s][i] == d);
                    WOP_AT_ADDR: if (is_sel(s)) begin m_mem[s][a] = d; m_val[s][a] = 1; end
                    WOP_AT_HIT:  if (s == ho) begin m_mem[s][first_hit(s)] = d; m_val[s][first_hit(s)] = 1; end
                    WOP_AT_FREE: if (s == fo) begin m_mem[s][first_free(s)] = d; m_val[s][first_free(s)] = 1; end
                    WOP_CLEAR:   if (is_sel(s)) m_val[s][a] = 0;
                    WOP_PAGE:    if (is_sel(s)) m_page[s] = d[PW-1:0];
                    WOP_SELECT:  m_dsel[s] = d[PW-1:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        en = '0; we = 1'b0;
    endtask

    task automatic do_rd(logic [2:0] o, int a, output logic [DW-1:0] bus, output logic [S-1:0] drv);
        @(negedge clk);
        en = '1; we = 1'b0; op = o; addr = AW'(a);
        #5;
        bus = '0;
        for (int s = 0; s < S; s++) bus |= rdata[s];
        drv = oe;
        @(posedge clk);
        #1;
        en = '0;
    endtask

    task automatic check_flags();
        bit up_m, up_f;
        @(negedge clk);
        up_m = 0; up_f = 1;
        for (int s = 0; s < S; s++) begin
            bool_chk("R2 ma_n", ma_n[s], !(first_hit(s) >= 0));
            bool_chk("R2 mm_n", mm_n[s], !(hit_count(s) > 1));
            up_m = up_m || (first_hit(s) >= 0);
            up_f = up_f && (first_free(s) < 0);
            bool_chk("R4 mf_n", mf_n[s], !up_m);
            bool_chk("R5 ff_n", ff_n[s], !up_f);
        end
    endtask

    task automatic bool_chk(string req, logic act, bit exp);
        check(req, DW'(act), DW'(exp));
    endtask

    task automatic check_read(logic [2:0] o, int a);
        logic [DW-1:0] bus, exp;
        logic [S-1:0]  drv, exp_drv;
        int ow, idx;
        exp = '0; exp_drv = '0;
        ow = (o == ROP_FREE) ? free_owner() : hit_owner();
        if (ow >= 0) begin
            exp_drv = S'(1) << ow;
            idx = (o == ROP_FREE) ? first_free(ow) : first_hit(ow);
            case (o)
                ROP_STATUS: begin
                    exp[AW-1:0] = AW'(idx); exp[AW +: PW] = m_page[ow];
                    exp[31] = 1'b1; exp[30] = hit_count(ow) > 1; exp[29] = first_free(ow) < 0;
                end
                ROP_HITWORD: exp = m_mem[ow][idx];
                ROP_FREE:    begin exp[AW-1:0] = AW'(idx); exp[AW +: PW] = m_page[ow]; end
                ROP_PAGE:    exp[PW-1:0] = m_page[ow];
                ROP_SELECT:  exp[PW-1:0] = m_dsel[ow];
                ROP_WORD:    exp = m_mem[ow][a];
                default: begin exp_drv = '0; end
            endcase
        end
        do_rd(o, a, bus, drv);
        check((o == ROP_FREE) ? "R7 driver" : "R6 driver", DW'(drv), DW'(exp_drv));
        case (o)
            ROP_STATUS: check("R3 status word", bus, exp);
            ROP_FREE:   check("R7 next-free word", bus, exp);
            ROP_PAGE:   check("R11 page read", bus, exp);
            ROP_SELECT: check("R11 select read", bus, exp);
            default:    check("R6 read data", bus, exp);
        endcase
    endtask

    task automatic check_all_reads();
        for (int o = 0; o <= 5; o++) check_read(3'(o), $urandom_range(0, N-1));
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        en = '0; we = 0; op = '0; addr = '0; wdata = '0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_flags();
        check_all_reads();

        // R11: per-slice page load via enables
        for (int s = 0; s < S; s++) do_wr(S'(1) << s, WOP_PAGE, 0, DW'(s + 1));
        check_read(ROP_FREE, 0);

        // R8: select targets slice with page 2 only
        do_wr('1, WOP_SELECT, 0, 32'd2);
        do_wr('1, WOP_AT_ADDR, 5, pool[0]);
        do_wr('1, WOP_SELECT, 0, 32'hFFFF);
        do_wr('1, WOP_COMPARE, 0, pool[0]);
        check_flags();
        check_all_reads();

        // R6/R9: same word in two slices, upstream one owns
        do_wr(3'b001, WOP_AT_ADDR, 6, pool[0]);
        do_wr('1, WOP_COMPARE, 0, pool[0]);
        check_flags();
        check_all_reads();
        do_wr('1, WOP_AT_HIT, 0, pool[1]);
        do_wr('1, WOP_COMPARE, 0, pool[1]);
        check_flags();
        check_all_reads();

        // R2: multiple match
        do_wr(3'b001, WOP_AT_ADDR, 1, pool[2]);
        do_wr(3'b001, WOP_AT_ADDR, 3, pool[2]);
        do_wr('1, WOP_COMPARE, 0, pool[2]);
        check_flags();
        check_read(ROP_STATUS, 0);

        // R12: disabled write ignored
        do_wr('0, WOP_CLEAR, 1, 0);
        do_wr('0, WOP_SELECT, 0, 32'h0);
        check_flags();
        check_all_reads();

        // constrained random phase
        for (int k = 0; k < 300; k++) begin
            logic [S-1:0] mask;
            logic [2:0]   o;
            logic [DW-1:0] d;
            int r = $urandom_range(0, 99);
            mask = ($urandom_range(0, 3) == 0) ? S'($urandom_range(0, 7)) : '1;
            d = pool[$urandom_range(0, 3)];
            if (r < 25) o = WOP_COMPARE;
            else if (r < 45) o = WOP_AT_ADDR;
            else if (r < 55) o = WOP_AT_HIT;
            else if (r < 72) o = WOP_AT_FREE;
            else if (r < 90) o = WOP_CLEAR;
            else begin
                o = WOP_SELECT;
                case ($urandom_range(0, 3))
                    0: d = 32'd1;
                    1: d = 32'd3;
                    2: d = 32'd7;
                    default: d = 32'hFFFF;
                endcase
            end
            do_wr(mask, o, $urandom_range(0, N-1), d);
            check_flags();
            check_read(3'($urandom_range(0, 5)), $urandom_range(0, N-1));
        end

        // R10: fill the whole chain, then one more next-free write
        do_wr('1, WOP_SELECT, 0, 32'hFFFF);
        for (int k = 0; k < S * N; k++) do_wr('1, WOP_AT_FREE, 0, pool[3]);
        check_flags();
        check_read(ROP_FREE, 0);
        do_wr('1, WOP_AT_FREE, 0, pool[1]);
        do_wr('1, WOP_COMPARE, 0, pool[1]);
        check_flags();
        check_all_reads();

        // R8: clear frees a word in the last slice only
        do_wr(3'b100, WOP_CLEAR, 2, 0);
        check_flags();
        check_read(ROP_FREE, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule